// File: doc/BRIEF.md
# Single-Rate Token Bucket Policer

The block meters a stream of received packets against one committed token bucket. The bucket fills on a timed tick. Each packet that arrives is charged a token cost. Every packet gets a color, and that color picks a pass or drop action. All quantities are held in fixed point with eight fractional bits. Quantities are given as a mantissa and an exponent pair, meaning (1 + M/256) * 2^E tokens. A token is one byte in byte mode. In packet-count mode a token is one packet.

A profile is loaded by pulsing `cfg_wr` with the profile fields on the `cfg_*` inputs. Loading a profile fills the bucket and restarts the refill timer. While the profile is unchanged, `pkt_vld` is pulsed once per packet, with the packet length and any incoming color. The verdict for that packet appears on the `res_*` outputs in the next cycle.

Top module: `srtb_policer`

## Requirements
- R1: `res_vld` is high in exactly the cycle after each cycle in which `pkt_vld` is high, and low at all other times.
- R2: A refill tick happens every 2 * 2^rate_div microseconds, where one microsecond is CLK_PER_US clock cycles. The first tick comes in the last cycle of the first period after a profile load or after reset. Each tick adds (1 + rate_man/256) * 2^rate_exp tokens.
- R3: The bucket never holds more than (1 + burst_man/256) * 2^burst_exp tokens. The pair burst_exp = 24 with burst_man = 0 means a zero-sized bucket. The same pair as a rate means no refill.
- R4: A metered packet costs max((pkt_mode ? 0 : len - len_ofs) + (adj_man/256 - 1) * 2^adj_exp, 0) tokens, computed exactly in 1/256-token units. adj_man is 9 bits wide.
- R5: With pkt_mode = 1, adj_man = 384 and adj_exp = 1, every packet costs exactly one token.
- R6: A metered packet is green when the bucket holds at least its cost, and the cost is then subtracted. Otherwise the packet is red and the bucket is not charged.
- R7: The color codes are 0 for green, 1 for yellow and 2 for red. The block only ever reports green or red.
- R8: Color mode 3 is color-blind, and in it `pkt_color` has no effect. In any other color mode, an incoming red packet (`pkt_color` = 2) is reported red and the bucket is not charged.
- R9: `res_action` is the configured action for the reported color. `res_drop` is high exactly when that action is 1, which means drop. Action 0 means pass.
- R10: After reset, and after each profile load, the bucket is full. The reset profile is all zero fields, color mode 3, green and yellow action 0, and red action 1.
- R11: When a packet and a refill tick fall in the same cycle, the packet is judged on the level before the refill. Both the charge and the refill are then applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load profile, fill bucket, restart timer |
| cfg_rate_man | input | 8 | Refill amount mantissa |
| cfg_rate_exp | input | 5 | Refill amount exponent |
| cfg_rate_div | input | 4 | Refill period scale (2 * 2^div us) |
| cfg_burst_man | input | 8 | Bucket ceiling mantissa |
| cfg_burst_exp | input | 5 | Bucket ceiling exponent |
| cfg_adj_man | input | 9 | Per-packet adjust mantissa |
| cfg_adj_exp | input | 5 | Per-packet adjust exponent |
| cfg_len_ofs | input | 8 | Bytes subtracted from the length |
| cfg_pkt_mode | input | 1 | 1: ignore length (packet-count mode) |
| cfg_color_mode | input | 2 | 3: color-blind, else color-aware |
| cfg_act_green | input | 2 | Action for green |
| cfg_act_yellow | input | 2 | Action for yellow |
| cfg_act_red | input | 2 | Action for red |
| pkt_vld | input | 1 | Packet strobe |
| pkt_len | input | 16 | Packet length in bytes |
| pkt_color | input | 2 | Incoming color |
| res_vld | output | 1 | Verdict valid |
| res_color | output | 2 | Verdict color |
| res_action | output | 2 | Verdict action code |
| res_drop | output | 1 | Verdict is drop |

## Verification
Each verdict is registered once, so the bench drives a packet just after a rising edge and reads the result just after the next rising edge. Back-to-back packets therefore overlap each read with the next drive. Refill ticks land in cycle k*T-1 after a profile load, where T = 2^(div+1) * CLK_PER_US. A token added there first serves the packet in cycle k*T. The refill, saturation and same-cycle checks count their idle and packet cycles from the load to hit those exact cycles. The green count over a back-to-back stream is then a closed-form function of the number of elapsed ticks.

// File: rtl/srtb_pkg.sv
package srtb_pkg;
  localparam int FRAC_W    = 8;
  localparam int MAN_W     = 8;
  localparam int EXP_W     = 5;
  localparam int ADJ_MAN_W = 9;
  localparam int DIV_W     = 4;
  localparam int LEN_W     = 16;
  localparam int OFS_W     = 8;
  localparam int ACT_W     = 2;
  localparam int CLR_W     = 2;
  localparam int FP_W      = 48;
  localparam int SUM_W     = FP_W + 2;
  localparam int ZERO_EXP  = 24;

  localparam logic [CLR_W-1:0] CLR_GREEN  = 2'd0;
  localparam logic [CLR_W-1:0] CLR_YELLOW = 2'd1;
  localparam logic [CLR_W-1:0] CLR_RED    = 2'd2;
  localparam logic [ACT_W-1:0] ACT_PASS   = 2'd0;
  localparam logic [ACT_W-1:0] ACT_DROP   = 2'd1;
  localparam logic [1:0]       BLIND_MODE = 2'd3;

  typedef struct packed {
    logic [MAN_W-1:0]     rate_man;
    logic [EXP_W-1:0]     rate_exp;
    logic [DIV_W-1:0]     rate_div;
    logic [MAN_W-1:0]     burst_man;
    logic [EXP_W-1:0]     burst_exp;
    logic [ADJ_MAN_W-1:0] adj_man;
    logic [EXP_W-1:0]     adj_exp;
    logic [OFS_W-1:0]     len_ofs;
    logic                 pkt_mode;
    logic [1:0]           color_mode;
    logic [ACT_W-1:0]     act_green;
    logic [ACT_W-1:0]     act_yellow;
    logic [ACT_W-1:0]     act_red;
  } prof_t;

  // (1 + man/256) * 2^ex tokens, as a count of 1/256 tokens
  function automatic logic [FP_W-1:0] me_to_fp(input logic [MAN_W-1:0] man,
                                               input logic [EXP_W-1:0] ex);
    if (ex == EXP_W'(ZERO_EXP) && man == '0) return '0;
    return FP_W'({1'b1, man}) << ex;
  endfunction

  // per-packet charge in 1/256 tokens, clamped at zero
  function automatic logic [FP_W-1:0] pkt_cost(input logic [LEN_W-1:0]     len,
                                               input logic [OFS_W-1:0]     ofs,
                                               input logic                 pmode,
                                               input logic [ADJ_MAN_W-1:0] am,
                                               input logic [EXP_W-1:0]     ae);
    logic signed [SUM_W-1:0] byte_part;
    logic signed [SUM_W-1:0] adj_part;
    logic signed [SUM_W-1:0] total;
    byte_part = $signed(SUM_W'(len)) - $signed(SUM_W'(ofs));
    byte_part = pmode ? '0 : (byte_part <<< FRAC_W);
    adj_part  = $signed(SUM_W'(am)) - $signed(SUM_W'(1 << FRAC_W));
    adj_part  = adj_part <<< ae;
    total     = byte_part + adj_part;
    if (total < 0) return '0;
    return total[FP_W-1:0];
  endfunction
endpackage

// File: rtl/srtb_tick_gen.sv
module srtb_tick_gen
  import srtb_pkg::*;
#(
  parameter int CLK_PER_US = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] rate_div,
  output logic             us_stb,
  output logic             tick
);
  localparam int US_W  = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int PER_W = (1 << DIV_W) + 1;

  logic [US_W-1:0]  us_cnt;
  logic [PER_W-1:0] per_cnt;
  logic [PER_W-1:0] per_last;

  assign us_stb   = (us_cnt == US_W'(CLK_PER_US - 1));
  assign per_last = (PER_W'(1) << ({1'b0, rate_div} + 5'd1)) - PER_W'(1);
  assign tick     = us_stb && (per_cnt == per_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_cnt  <= '0;
      per_cnt <= '0;
    end else if (restart) begin
      us_cnt  <= '0;
      per_cnt <= '0;
    end else begin
      us_cnt <= us_stb ? '0 : us_cnt + US_W'(1);
      if (us_stb) per_cnt <= tick ? '0 : per_cnt + PER_W'(1);
    end
  end
endmodule

// File: rtl/srtb_bucket.sv
module srtb_bucket
  import srtb_pkg::*;
#(
  parameter logic [FP_W-1:0] INIT_LEVEL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [FP_W-1:0] load_level,
  input  logic [FP_W-1:0] ceil_fp,
  input  logic            tick,
  input  logic [FP_W-1:0] refill_fp,
  input  logic            charge,
  input  logic [FP_W-1:0] cost_fp,
  output logic            fits,
  output logic [FP_W-1:0] level
);
  logic [FP_W-1:0] level_d;
  logic [FP_W:0]   after_chg;
  logic [FP_W:0]   with_fill;

  assign fits = (level >= cost_fp);

  always_comb begin
    after_chg = {1'b0, level} - (charge ? {1'b0, cost_fp} : '0);
    with_fill = after_chg + (tick ? {1'b0, refill_fp} : '0);
    level_d   = (with_fill > {1'b0, ceil_fp}) ? ceil_fp : with_fill[FP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level <= INIT_LEVEL;
    else if (load) level <= load_level;
    else           level <= level_d;
  end
endmodule

// File: rtl/srtb_result.sv
module srtb_result
  import srtb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [CLR_W-1:0] in_color,
  input  logic [ACT_W-1:0] act_green,
  input  logic [ACT_W-1:0] act_yellow,
  input  logic [ACT_W-1:0] act_red,
  output logic             res_vld,
  output logic [CLR_W-1:0] res_color,
  output logic [ACT_W-1:0] res_action,
  output logic             res_drop
);
  logic [ACT_W-1:0] act_sel;

  always_comb begin
    case (in_color)
      CLR_GREEN:  act_sel = act_green;
      CLR_YELLOW: act_sel = act_yellow;
      default:    act_sel = act_red;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld    <= 1'b0;
      res_color  <= CLR_GREEN;
      res_action <= ACT_PASS;
      res_drop   <= 1'b0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) begin
        res_color  <= in_color;
        res_action <= act_sel;
        res_drop   <= (act_sel == ACT_DROP);
      end
    end
  end
endmodule

// File: rtl/srtb_policer.sv
module srtb_policer
  import srtb_pkg::*;
#(
  parameter int CLK_PER_US = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [MAN_W-1:0]     cfg_rate_man,
  input  logic [EXP_W-1:0]     cfg_rate_exp,
  input  logic [DIV_W-1:0]     cfg_rate_div,
  input  logic [MAN_W-1:0]     cfg_burst_man,
  input  logic [EXP_W-1:0]     cfg_burst_exp,
  input  logic [ADJ_MAN_W-1:0] cfg_adj_man,
  input  logic [EXP_W-1:0]     cfg_adj_exp,
  input  logic [OFS_W-1:0]     cfg_len_ofs,
  input  logic                 cfg_pkt_mode,
  input  logic [1:0]           cfg_color_mode,
  input  logic [ACT_W-1:0]     cfg_act_green,
  input  logic [ACT_W-1:0]     cfg_act_yellow,
  input  logic [ACT_W-1:0]     cfg_act_red,
  input  logic                 pkt_vld,
  input  logic [LEN_W-1:0]     pkt_len,
  input  logic [CLR_W-1:0]     pkt_color,
  output logic                 res_vld,
  output logic [CLR_W-1:0]     res_color,
  output logic [ACT_W-1:0]     res_action,
  output logic                 res_drop
);
  localparam prof_t PROF_RST = '{
    rate_man: '0, rate_exp: '0, rate_div: '0, burst_man: '0, burst_exp: '0,
    adj_man: '0, adj_exp: '0, len_ofs: '0, pkt_mode: 1'b0,
    color_mode: BLIND_MODE, act_green: ACT_PASS, act_yellow: ACT_PASS,
    act_red: ACT_DROP};
  localparam logic [FP_W-1:0] RST_LEVEL = me_to_fp(PROF_RST.burst_man, PROF_RST.burst_exp);

  prof_t prof_q;
  prof_t prof_d;

  always_comb begin
    prof_d.rate_man   = cfg_rate_man;
    prof_d.rate_exp   = cfg_rate_exp;
    prof_d.rate_div   = cfg_rate_div;
    prof_d.burst_man  = cfg_burst_man;
    prof_d.burst_exp  = cfg_burst_exp;
    prof_d.adj_man    = cfg_adj_man;
    prof_d.adj_exp    = cfg_adj_exp;
    prof_d.len_ofs    = cfg_len_ofs;
    prof_d.pkt_mode   = cfg_pkt_mode;
    prof_d.color_mode = cfg_color_mode;
    prof_d.act_green  = cfg_act_green;
    prof_d.act_yellow = cfg_act_yellow;
    prof_d.act_red    = cfg_act_red;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prof_q <= PROF_RST;
    else if (cfg_wr) prof_q <= prof_d;
  end

  // named internal events
  logic            us_stb;
  logic            tick;
  logic            fits;
  logic            aware_red;
  logic            meter_req;
  logic            charge;
  logic [FP_W-1:0] ceil_fp;
  logic [FP_W-1:0] load_ceil;
  logic [FP_W-1:0] refill_fp;
  logic [FP_W-1:0] cost_fp;
  logic [FP_W-1:0] bkt_level;
  logic [CLR_W-1:0] verdict;

  assign ceil_fp   = me_to_fp(prof_q.burst_man, prof_q.burst_exp);
  assign load_ceil = me_to_fp(prof_d.burst_man, prof_d.burst_exp);
  assign refill_fp = me_to_fp(prof_q.rate_man, prof_q.rate_exp);
  assign cost_fp   = pkt_cost(pkt_len, prof_q.len_ofs, prof_q.pkt_mode,
                              prof_q.adj_man, prof_q.adj_exp);
  assign aware_red = (prof_q.color_mode != BLIND_MODE) && (pkt_color == CLR_RED);
  assign meter_req = pkt_vld && !aware_red;
  assign charge    = meter_req && fits;
  assign verdict   = charge ? CLR_GREEN : CLR_RED;

  srtb_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_wr),
    .rate_div(prof_q.rate_div),
    .us_stb  (us_stb),
    .tick    (tick)
  );

  srtb_bucket #(.INIT_LEVEL(RST_LEVEL)) u_bucket (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_wr),
    .load_level(load_ceil),
    .ceil_fp   (ceil_fp),
    .tick      (tick),
    .refill_fp (refill_fp),
    .charge    (charge),
    .cost_fp   (cost_fp),
    .fits      (fits),
    .level     (bkt_level)
  );

  srtb_result u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (pkt_vld),
    .in_color  (verdict),
    .act_green (prof_q.act_green),
    .act_yellow(prof_q.act_yellow),
    .act_red   (prof_q.act_red),
    .res_vld   (res_vld),
    .res_color (res_color),
    .res_action(res_action),
    .res_drop  (res_drop)
  );
endmodule

// File: rtl/srtb_policer_chk.sv
module srtb_policer_chk
  import srtb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             pkt_vld,
  input logic             tick,
  input logic             charge,
  input logic [FP_W-1:0]  level,
  input logic [FP_W-1:0]  cost,
  input logic [FP_W-1:0]  ceil_fp,
  input logic             res_vld,
  input logic [CLR_W-1:0] res_color
);
  assert_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_vld |=> res_vld);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_vld |=> !res_vld);

  assert_under_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ceil_fp);

  assert_red_keeps_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_vld && !charge && !tick && !cfg_wr) |=> (level == $past(level)));

  assert_green_charged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (charge && !tick && !cfg_wr) |=> (level == $past(level) - $past(cost)));

  assert_no_yellow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_color != CLR_YELLOW));
endmodule

bind srtb_policer srtb_policer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .pkt_vld  (pkt_vld),
  .tick     (tick),
  .charge   (charge),
  .level    (bkt_level),
  .cost     (cost_fp),
  .ceil_fp  (ceil_fp),
  .res_vld  (res_vld),
  .res_color(res_color)
);

// File: tb/srtb_policer_test.sv
module srtb_policer_test;
  localparam int CPU = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] rm = '0, bm = '0, ofs = '0;
  logic [4:0] re = '0, be = '0, ae = '0;
  logic [3:0] rd = '0;
  logic [8:0] am = '0;
  logic       pm = 1'b0;
  logic [1:0] cm = 2'd3, ag = '0, ay = '0, ar = 2'd1;
  logic       pkt_vld = 1'b0;
  logic [15:0] pkt_len = '0;
  logic [1:0] pkt_color = '0;
  logic       res_vld, res_drop;
  logic [1:0] res_color, res_action;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  srtb_policer #(.CLK_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .cfg_rate_man(rm), .cfg_rate_exp(re), .cfg_rate_div(rd),
    .cfg_burst_man(bm), .cfg_burst_exp(be),
    .cfg_adj_man(am), .cfg_adj_exp(ae), .cfg_len_ofs(ofs),
    .cfg_pkt_mode(pm), .cfg_color_mode(cm),
    .cfg_act_green(ag), .cfg_act_yellow(ay), .cfg_act_red(ar),
    .pkt_vld(pkt_vld), .pkt_len(pkt_len), .pkt_color(pkt_color),
    .res_vld(res_vld), .res_color(res_color), .res_action(res_action),
    .res_drop(res_drop));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic load(input logic [7:0] r_m, input logic [4:0] r_e, input logic [3:0] r_d,
                      input logic [7:0] b_m, input logic [4:0] b_e,
                      input logic [8:0] a_m, input logic [4:0] a_e, input logic [7:0] o,
                      input logic p_m, input logic [1:0] c_m,
                      input logic [1:0] a_g, input logic [1:0] a_y, input logic [1:0] a_r);
    rm = r_m; re = r_e; rd = r_d; bm = b_m; be = b_e; am = a_m; ae = a_e;
    ofs = o; pm = p_m; cm = c_m; ag = a_g; ay = a_y; ar = a_r;
    cfg_wr = 1'b1;
    step();
    cfg_wr = 1'b0;
  endtask

  // one-token packet mode, no refill, given ceiling
  task automatic load_pps(input logic [7:0] b_m, input logic [4:0] b_e, input logic [1:0] c_m);
    load(8'd0, 5'd24, 4'd0, b_m, b_e, 9'd384, 5'd1, 8'd0, 1'b1, c_m, 2'd0, 2'd0, 2'd1);
  endtask

  task automatic send(input logic [15:0] len, input logic [1:0] col,
                      output logic [1:0] o_col, output logic [1:0] o_act,
                      output logic o_drop, output logic o_vld);
    pkt_len = len;
    pkt_color = col;
    pkt_vld = 1'b1;
    step();
    pkt_vld = 1'b0;
    o_col = res_color;
    o_act = res_action;
    o_drop = res_drop;
    o_vld = res_vld;
  endtask

  function automatic longint exp_cost(input longint len, input longint o, input bit p,
                                      input longint a_m, input int a_e);
    longint s;
    s = (p ? 0 : (len - o) * 256) + (a_m - 256) * (longint'(1) << a_e);
    return (s < 0) ? 0 : s;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [1:0] c, a;
    logic dr, v;
    int greens;
    int sweep_adj_man [5] = '{0, 200, 256, 384, 511};
    int sweep_adj_exp [3] = '{0, 1, 3};
    longint ceilv, cst;

    idle(3);
    rst_n = 1'b1;
    #1;
    // R10 reset state, reset profile full bucket
    check(res_vld == 1'b0, "R10 reset res_vld", res_vld, 0);
    check(res_drop == 1'b0, "R10 reset res_drop", res_drop, 0);
    send(16'd2, 2'd0, c, a, dr, v);
    check(v == 1'b1, "R1 valid after packet", v, 1);
    check(c == 2'd0, "R10 full after reset", c, 0);
    send(16'd3, 2'd0, c, a, dr, v);
    check(c == 2'd2 && dr == 1'b1, "R10 reset red action drop", c, 2);
    step();
    check(res_vld == 1'b0, "R1 no packet no valid", res_vld, 0);

    // R4 cost sweep against a ceiling of 2176/256 tokens
    ceilv = (256 + 16) << 3;
    foreach (sweep_adj_exp[ie]) foreach (sweep_adj_man[im])
      for (int o = 0; o <= 5; o += 5)
        for (int p = 0; p < 2; p++)
          for (int len = 0; len <= 20; len++) begin
            load(8'd0, 5'd24, 4'd0, 8'd16, 5'd3, 9'(sweep_adj_man[im]),
                 5'(sweep_adj_exp[ie]), 8'(o), 1'(p), 2'd3, 2'd0, 2'd0, 2'd1);
            send(16'(len), 2'd0, c, a, dr, v);
            cst = exp_cost(len, o, p[0], sweep_adj_man[im], sweep_adj_exp[ie]);
            check(c == ((cst <= ceilv) ? 2'd0 : 2'd2), "R4 cost vs ceiling", c,
                  (cst <= ceilv) ? 0 : 2);
          end

    // R5 R6 packet mode depletion of a 10-token bucket
    load_pps(8'd64, 5'd3, 2'd3);
    greens = 0;
    for (int i = 0; i < 12; i++) begin
      send(16'd1500, 2'd0, c, a, dr, v);
      if (c == 2'd0) greens++;
    end
    check(greens == 10, "R5 one token per packet", greens, 10);
    check(c == 2'd2, "R6 empty bucket gives red", c, 2);

    // R6 byte mode: red leaves bucket untouched
    load(8'd0, 5'd24, 4'd0, 8'd64, 5'd3, 9'd256, 5'd0, 8'd0, 1'b0, 2'd3, 2'd0, 2'd0, 2'd1);
    send(16'd4, 2'd0, c, a, dr, v);
    check(c == 2'd0, "R6 first 4 bytes green", c, 0);
    send(16'd4, 2'd0, c, a, dr, v);
    check(c == 2'd0, "R6 second 4 bytes green", c, 0);
    send(16'd4, 2'd0, c, a, dr, v);
    check(c == 2'd2, "R6 4 bytes over 2 left red", c, 2);
    send(16'd2, 2'd0, c, a, dr, v);
    check(c == 2'd0, "R6 red did not charge", c, 0);
    send(16'd1, 2'd0, c, a, dr, v);
    check(c == 2'd2, "R6 drained", c, 2);

    // R3 zero-sized bucket
    load_pps(8'd0, 5'd24, 2'd3);
    send(16'd64, 2'd0, c, a, dr, v);
    check(c == 2'd2, "R3 zero bucket red", c, 2);
    load(8'd0, 5'd24, 4'd0, 8'd0, 5'd24, 9'd256, 5'd0, 8'd0, 1'b1, 2'd3, 2'd0, 2'd0, 2'd1);
    send(16'd64, 2'd0, c, a, dr, v);
    check(c == 2'd0, "R3 zero bucket zero cost green", c, 0);

    // R3 saturation: 16 tokens per tick, ceiling 10, tick at cycle 63
    load(8'd0, 5'd4, 4'd4, 8'd64, 5'd3, 9'd384, 5'd1, 8'd0, 1'b1, 2'd3, 2'd0, 2'd0, 2'd1);
    idle(70);
    greens = 0;
    for (int i = 0; i < 12; i++) begin
      send(16'd1, 2'd0, c, a, dr, v);
      if (c == 2'd0) greens++;
    end
    check(greens == 10, "R3 refill capped at ceiling", greens, 10);

    // R2 refill count over a 200-packet stream
    for (int t = 0; t < 3; t++) begin
      int div_v  = (t == 2) ? 2 : 1;
      int man_v  = (t == 1) ? 128 : 0;
      int period = (2 << div_v) * CPU;
      int ticks  = 199 / period;
      int expg   = (2560 + ticks * (256 + man_v)) / 256;
      load(8'(man_v), 5'd0, 4'(div_v), 8'd64, 5'd3, 9'd384, 5'd1, 8'd0, 1'b1,
           2'd3, 2'd0, 2'd0, 2'd1);
      greens = 0;
      for (int i = 0; i < 200; i++) begin
        send(16'd100, 2'd0, c, a, dr, v);
        if (c == 2'd0) greens++;
      end
      check(greens == expg, "R2 greens from refill ticks", greens, expg);
    end

    // R11 tick and packet in the same cycle (tick at cycle 7)
    load(8'd0, 5'd0, 4'd1, 8'd0, 5'd0, 9'd384, 5'd1, 8'd0, 1'b1, 2'd3, 2'd0, 2'd0, 2'd1);
    send(16'd1, 2'd0, c, a, dr, v);
    check(c == 2'd0, "R11 cycle 0 green", c, 0);
    idle(6);
    send(16'd1, 2'd0, c, a, dr, v);
    check(c == 2'd2, "R11 judged before refill", c, 2);
    send(16'd1, 2'd0, c, a, dr, v);
    check(c == 2'd0, "R11 refill applied", c, 0);

    // R8 color-aware and color-blind
    load_pps(8'd0, 5'd0, 2'd0);
    send(16'd1, 2'd2, c, a, dr, v);
    check(c == 2'd2 && dr == 1'b1, "R8 aware incoming red", c, 2);
    send(16'd1, 2'd0, c, a, dr, v);
    check(c == 2'd0, "R8 aware red did not charge", c, 0);
    send(16'd1, 2'd1, c, a, dr, v);
    check(c == 2'd2, "R8 aware drained", c, 2);
    load_pps(8'd0, 5'd0, 2'd3);
    send(16'd1, 2'd2, c, a, dr, v);
    check(c == 2'd0, "R8 blind ignores incoming red", c, 0);
    check(c != 2'd1, "R7 never yellow", c, 0);

    // R9 action mapping sweep
    for (int g = 0; g < 4; g++)
      for (int r = 0; r < 4; r++) begin
        load(8'd0, 5'd24, 4'd0, 8'd0, 5'd0, 9'd384, 5'd1, 8'd0, 1'b1, 2'd3,
             2'(g), 2'd0, 2'(r));
        send(16'd1, 2'd0, c, a, dr, v);
        check(c == 2'd0 && a == 2'(g) && dr == (g == 1), "R9 green action", a, g);
        send(16'd1, 2'd0, c, a, dr, v);
        check(c == 2'd2 && a == 2'(r) && dr == (r == 1), "R9 red action", a, r);
      end

    done = 1;
    summary();
    $finish;
  end
endmodule